// File: doc/BRIEF.md
# Dual-Width Condition-Code Flag Unit

This block sits at the end of a 64-bit integer execute stage and turns one operation into a registered result plus two four-bit condition-code sets. The narrow set describes the low 32 bits of the result and the wide set describes all 64 bits. Both sets come from the same operation and are written in the same cycle. Arithmetic and tagged operations compute their own result. Logic and divide operations pass in a result that was produced elsewhere, and the unit derives the flags from it.

Two of the operations need extra care. The carry-chained add and subtract take their carry-in from the stored narrow carry flag. Tagged arithmetic treats the two low bits of each operand as a type tag. In the plain tagged forms a nonzero tag shows up as overflow. In the trapping forms a nonzero tag, or a signed 32-bit overflow, raises a one-cycle trap request, and in that case the result and the flags are not written. The unit does not contain the divider, the code that handles the trap, or the branch-condition decoder.

Top module: `ccflag_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `result`, `flags_lo`, `flags_hi` and `tag_trap` are all zero.
- R2: The `op_sel` encoding is 0 add, 1 add-with-carry, 2 tagged add, 3 trapping tagged add, 4 subtract, 5 subtract-with-borrow, 6 tagged subtract, 7 trapping tagged subtract, 8 logic pass-through and 9 divide. Nothing is written when `op_valid` is low or when `op_sel` is 10 to 15. Each flag output is packed as bit 3 N, bit 2 Z, bit 1 V and bit 0 C.
- R3: In the narrow set, N is result bit 31 and Z is set when result bits 31:0 are all zero. In the wide set, N is bit 63 and Z is set when all 64 bits are zero.
- R4: The add forms produce a+b. C is set when the result is unsigned-below `opnd_a`, evaluated separately on the low 32 bits and on all 64 bits. V is the sign bit (31 or 63) of NOT(a XOR b) AND (a XOR result).
- R5: The subtract forms produce a-b. C is set when `opnd_a` is unsigned-below `opnd_b` at each width. V is the sign bit of (a XOR b) AND (a XOR result).
- R6: Add-with-carry and subtract-with-borrow take the stored `flags_lo` C as their carry-in. When that carry-in is 1, the result is a+b+1 or a-b-1, and C uses less-or-equal: result<=a for add, a<=b for subtract.
- R7: The plain tagged add and subtract also set the narrow V when bits 1:0 of either operand are nonzero. The wide V ignores the tag.
- R8: The trapping tagged forms request a trap when either operand has nonzero bits 1:0, or when the narrow signed-overflow condition holds. When no trap is requested, they write N, Z and C at both widths and clear V at both widths.
- R9: When a trap is requested, `result` and both flag sets keep their previous values, and `tag_trap` is high for exactly the one cycle after the operation.
- R10: The logic operation passes `opnd_a` through as the result, sets N and Z, and clears V and C at both widths.
- R11: The divide operation takes `opnd_a` as the quotient and sets N and Z from it. The narrow V copies `div_ovf`, and the wide V and both C flags are cleared.
- R12: An operation presented in one cycle appears on `result` and on the flag outputs after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Write enable for the operation on the inputs |
| op_sel | input | 4 | Operation code (see R2) |
| opnd_a | input | 64 | First operand, or the quotient or logic result for pass-through |
| opnd_b | input | 64 | Second operand |
| div_ovf | input | 1 | Overflow indicator from the divider |
| result | output | 64 | Registered result |
| flags_lo | output | 4 | Registered {N,Z,V,C} for the low 32 bits |
| flags_hi | output | 4 | Registered {N,Z,V,C} for all 64 bits |
| tag_trap | output | 1 | One-cycle tag-overflow trap request |

## Verification
The stored narrow carry is the only internal state that feeds back into the datapath. If it is wrong, nothing shows until the next carry-chained operation, and then that operation's result is off by one and its C flag changes. For this reason the stimulus table places every add-with-carry and subtract-with-borrow right after an operation that sets a known carry. A wrong write-enable shows up one cycle after a trap or an idle cycle, as a change in `result` or in the flags where none should occur. A trap request that is stuck high or that is missing shows up on `tag_trap` in the following cycle.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_TADD  = 4'd2,
    OP_TADDT = 4'd3,
    OP_SUB   = 4'd4,
    OP_SUBC  = 4'd5,
    OP_TSUB  = 4'd6,
    OP_TSUBT = 4'd7,
    OP_LOGIC = 4'd8,
    OP_DIV   = 4'd9
  } ccop_e;

  // Packed so that bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_t;

endpackage

// File: rtl/ccflag_addsub.sv
// Adder/subtractor split into a narrow and an upper segment, so that the
// carry out of the narrow segment is available without a second adder.
module ccflag_addsub #(
  parameter int W    = 64,
  parameter int LO_W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_lo_o,
  output logic         c_hi_o,
  output logic         v_lo_o,
  output logic         v_hi_o
);
  localparam int HI_W = W - LO_W;

  logic [W-1:0]    bx;
  logic            cin_eff;
  logic [LO_W:0]   seg_lo;
  logic [HI_W:0]   seg_hi;

  // a - b - cin is computed as a + ~b + (1 - cin).
  assign bx      = sub_i ? ~b_i : b_i;
  assign cin_eff = sub_i ? ~cin_i : cin_i;

  assign seg_lo = {1'b0, a_i[LO_W-1:0]} + {1'b0, bx[LO_W-1:0]}
                + {{LO_W{1'b0}}, cin_eff};
  assign seg_hi = {1'b0, a_i[W-1:LO_W]} + {1'b0, bx[W-1:LO_W]}
                + {{HI_W{1'b0}}, seg_lo[LO_W]};

  assign sum_o = {seg_hi[HI_W-1:0], seg_lo[LO_W-1:0]};

  // For a subtraction, the borrow is the inverse of the raw carry out.
  assign c_lo_o = seg_lo[LO_W] ^ sub_i;
  assign c_hi_o = seg_hi[HI_W] ^ sub_i;

  // Signed overflow: the two addends have the same sign and the sum does not.
  assign v_lo_o = (a_i[LO_W-1] ~^ bx[LO_W-1]) & (a_i[LO_W-1] ^ sum_o[LO_W-1]);
  assign v_hi_o = (a_i[W-1] ~^ bx[W-1]) & (a_i[W-1] ^ sum_o[W-1]);

  always_comb begin
    if (!sub_i && !cin_i) begin
      assert_add_carry_R4 : assert ((sum_o[LO_W-1:0] < a_i[LO_W-1:0]) == c_lo_o);
    end
    if (sub_i && !cin_i) begin
      assert_sub_borrow_R5 : assert ((a_i < b_i) == c_hi_o);
    end
  end

endmodule

// File: rtl/ccflag_nzgen.sv
// Produces N and Z for the narrow lane (index 0) and the wide lane (index 1).
module ccflag_nzgen #(
  parameter int W    = 64,
  parameter int LO_W = 32
) (
  input  logic [W-1:0] res_i,
  output logic [1:0]   n_o,
  output logic [1:0]   z_o
);
  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    localparam int TOP = (gi == 0) ? LO_W - 1 : W - 1;
    assign n_o[gi] = res_i[TOP];
    assign z_o[gi] = ~|res_i[TOP:0];
  end
endmodule

// File: rtl/ccflag_tagchk.sv
// Reports whether either operand carries a nonzero tag field.
module ccflag_tagchk #(
  parameter int TAG_W = 2
) (
  input  logic [TAG_W-1:0] a_tag_i,
  input  logic [TAG_W-1:0] b_tag_i,
  output logic             tag_nz_o
);
  assign tag_nz_o = |(a_tag_i | b_tag_i);
endmodule

// File: rtl/ccflag_unit.sv
module ccflag_unit
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              div_ovf,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_lo,
  output logic [3:0]        flags_hi,
  output logic              tag_trap
);

  // ---------------------------------------------------------------------
  // Registered state
  // ---------------------------------------------------------------------
  logic [DATA_W-1:0] res_q;
  ccf_t              lo_q, hi_q;
  logic              trap_q;

  // ---------------------------------------------------------------------
  // Decode
  // ---------------------------------------------------------------------
  logic is_sub, uses_cin, pass_a, cin;

  assign is_sub   = op_sel inside {OP_SUB, OP_SUBC, OP_TSUB, OP_TSUBT};
  assign uses_cin = (op_sel == OP_ADDC) || (op_sel == OP_SUBC);
  assign pass_a   = (op_sel == OP_LOGIC) || (op_sel == OP_DIV);
  assign cin      = uses_cin & lo_q.c;

  // ---------------------------------------------------------------------
  // Datapath sub-blocks
  // ---------------------------------------------------------------------
  logic [DATA_W-1:0] sum;
  logic              c_lo, c_hi, v_lo, v_hi;
  logic              tag_nz;
  logic [DATA_W-1:0] nxt_res;
  logic [1:0]        n_vec, z_vec;

  ccflag_addsub #(.W(DATA_W), .LO_W(LO_W)) u_addsub (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sub_i  (is_sub),
    .cin_i  (cin),
    .sum_o  (sum),
    .c_lo_o (c_lo),
    .c_hi_o (c_hi),
    .v_lo_o (v_lo),
    .v_hi_o (v_hi)
  );

  ccflag_tagchk #(.TAG_W(TAG_W)) u_tagchk (
    .a_tag_i  (opnd_a[TAG_W-1:0]),
    .b_tag_i  (opnd_b[TAG_W-1:0]),
    .tag_nz_o (tag_nz)
  );

  assign nxt_res = pass_a ? opnd_a : sum;

  ccflag_nzgen #(.W(DATA_W), .LO_W(LO_W)) u_nzgen (
    .res_i (nxt_res),
    .n_o   (n_vec),
    .z_o   (z_vec)
  );

  // ---------------------------------------------------------------------
  // Next-state logic: every flag is rebuilt from scratch on each write
  // ---------------------------------------------------------------------
  ccf_t nxt_lo, nxt_hi;
  logic legal, trap_cond, wr_en, trap_req;

  always_comb begin
    nxt_lo    = '{n: n_vec[0], z: z_vec[0], v: v_lo, c: c_lo};
    nxt_hi    = '{n: n_vec[1], z: z_vec[1], v: v_hi, c: c_hi};
    legal     = 1'b1;
    trap_cond = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
      end
      OP_TADD, OP_TSUB: begin
        nxt_lo.v = v_lo | tag_nz;
      end
      OP_TADDT, OP_TSUBT: begin
        trap_cond = tag_nz | v_lo;
        nxt_lo.v  = 1'b0;
        nxt_hi.v  = 1'b0;
      end
      OP_LOGIC: begin
        nxt_lo.v = 1'b0;
        nxt_lo.c = 1'b0;
        nxt_hi.v = 1'b0;
        nxt_hi.c = 1'b0;
      end
      OP_DIV: begin
        nxt_lo.v = div_ovf;
        nxt_lo.c = 1'b0;
        nxt_hi.v = 1'b0;
        nxt_hi.c = 1'b0;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

  assign trap_req = op_valid & legal & trap_cond;
  assign wr_en    = op_valid & legal & ~trap_cond;

  // ---------------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      if (wr_en) begin
        res_q <= nxt_res;
        lo_q  <= nxt_lo;
        hi_q  <= nxt_hi;
      end
      trap_q <= trap_req;
    end
  end

  assign result   = res_q;
  assign flags_lo = lo_q;
  assign flags_hi = hi_q;
  assign tag_trap = trap_q;

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  assert_trap_nowrite_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    tag_trap |-> ($stable(result) && $stable(flags_lo) && $stable(flags_hi)));

  assert_trap_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    tag_trap |-> $past(op_valid));

  assert_idle_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(flags_lo) && $stable(flags_hi)));

  assert_logic_vc_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_LOGIC) |=> (flags_lo[1:0] == 2'b00 && flags_hi[1:0] == 2'b00));

  assert_trapvar_vclr_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel inside {OP_TADDT, OP_TSUBT}))
      |=> (tag_trap || (!flags_lo[1] && !flags_hi[1])));

  assert_zero_nest_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    flags_hi[2] |-> flags_lo[2]);

endmodule

// File: tb/ccflag_unit_bench.sv
module ccflag_unit_bench;

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic        dov;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  // Stimulus table. req picks the requirement each row exercises.
  localparam vec_t VECS [NV] = '{
    '{4'd0, 64'h0000_0000_FFFF_FFFF, 64'h1,                   1'b0, 4'd4},  // R4 narrow carry, narrow zero
    '{4'd0, 64'h0000_0000_7FFF_FFFF, 64'h1,                   1'b0, 4'd4},  // R4 narrow overflow
    '{4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                   1'b0, 4'd3},  // R3 both zero
    '{4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,                   1'b0, 4'd3},  // R3 wide negative
    '{4'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_FFFF_FFFB, 1'b0, 4'd4},  // R4 sets C for next
    '{4'd1, 64'h0000_0000_0000_0005, 64'h0000_0000_FFFF_FFFA, 1'b0, 4'd6},  // R6 cin=1, <= rule
    '{4'd4, 64'h3,                   64'h5,                   1'b0, 4'd5},  // R5 borrow
    '{4'd5, 64'h7,                   64'h7,                   1'b0, 4'd6},  // R6 cin=1, a<=b
    '{4'd4, 64'h0000_0000_8000_0000, 64'h1,                   1'b0, 4'd5},  // R5 narrow overflow
    '{4'd8, 64'h0,                   64'h0,                   1'b0, 4'd10}, // R10 zero, clears C
    '{4'd5, 64'h7,                   64'h7,                   1'b0, 4'd6},  // R6 cin=0
    '{4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   1'b0, 4'd6},  // R6 cin=0 add
    '{4'd2, 64'h1,                   64'h4,                   1'b0, 4'd7},  // R7 tag forces narrow V
    '{4'd2, 64'h4,                   64'h8,                   1'b0, 4'd7},  // R7 clean tag
    '{4'd6, 64'h10,                  64'h2,                   1'b0, 4'd7},  // R7 tagged subtract
    '{4'd3, 64'h8,                   64'hC,                   1'b0, 4'd8},  // R8 no trap
    '{4'd3, 64'h3,                   64'h4,                   1'b0, 4'd8},  // R8 tag trap
    '{4'd3, 64'h0000_0000_7FFF_FFFC, 64'h4,                   1'b0, 4'd8},  // R8 overflow trap
    '{4'd7, 64'h0000_0000_8000_0000, 64'h4,                   1'b0, 4'd8},  // R8 sub overflow trap
    '{4'd3, 64'h7FFF_FFFF_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 4'd8},  // R8 wide ovf only
    '{4'd7, 64'h10,                  64'h4,                   1'b0, 4'd8},  // R8 clean sub
    '{4'd9, 64'hFFFF_FFFF_8000_0000, 64'h0,                   1'b1, 4'd11}, // R11 div overflow
    '{4'd9, 64'h0,                   64'h0,                   1'b0, 4'd11}, // R11 zero quotient
    '{4'd8, 64'h0000_0000_8000_0000, 64'h0,                   1'b0, 4'd10}  // R10 narrow negative
  };

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [63:0] opnd_a, opnd_b;
  logic        div_ovf;
  logic [63:0] result;
  logic [3:0]  flags_lo, flags_hi;
  logic        tag_trap;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // Reference state
  logic [63:0] m_res;
  logic [3:0]  m_lo, m_hi;

  ccflag_unit u_ccflag_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .div_ovf  (div_ovf),
    .result   (result),
    .flags_lo (flags_lo),
    .flags_hi (flags_hi),
    .tag_trap (tag_trap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected behaviour, written from the requirement text.
  task automatic model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic dov, output logic [63:0] r, output logic [3:0] lo,
                       output logic [3:0] hi, output logic trap, output logic wr);
    logic ci, tnz, clo, chi, vlo, vhi, legal;
    logic [63:0] x;
    ci    = (op == 4'd1 || op == 4'd5) ? m_lo[0] : 1'b0;
    tnz   = (a[1:0] | b[1:0]) != 2'b00;
    legal = 1'b1;
    clo = 0; chi = 0; vlo = 0; vhi = 0; r = '0;
    if (op <= 4'd3) begin
      r   = a + b + {63'd0, ci};
      clo = ci ? (r[31:0] <= a[31:0]) : (r[31:0] < a[31:0]);
      chi = ci ? (r <= a) : (r < a);
      x   = ~(a ^ b) & (a ^ r);
      vlo = x[31]; vhi = x[63];
    end else if (op <= 4'd7) begin
      r   = a - b - {63'd0, ci};
      clo = ci ? (a[31:0] <= b[31:0]) : (a[31:0] < b[31:0]);
      chi = ci ? (a <= b) : (a < b);
      x   = (a ^ b) & (a ^ r);
      vlo = x[31]; vhi = x[63];
    end else if (op == 4'd8 || op == 4'd9) begin
      r   = a;
      vlo = (op == 4'd9) && dov;
    end else begin
      legal = 1'b0;
    end
    trap = 1'b0;
    if (op == 4'd2 || op == 4'd6) vlo = vlo | tnz;
    if (op == 4'd3 || op == 4'd7) begin
      trap = tnz | vlo;
      vlo  = 1'b0;
      vhi  = 1'b0;
    end
    wr = legal && !trap;
    lo = {r[31], r[31:0] == 32'd0, vlo, clo};
    hi = {r[63], r == 64'd0, vhi, chi};
  endtask

  task automatic run_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic dov, input string req);
    logic [63:0] r;
    logic [3:0]  lo, hi;
    logic        trap, wr;
    model(op, a, b, dov, r, lo, hi, trap, wr);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; div_ovf = dov;
    @(negedge clk);
    op_valid = 1'b0;
    if (wr) begin
      m_res = r; m_lo = lo; m_hi = hi;
    end
    chk(req, "result", result, m_res);
    chk(req, "flags_lo", {60'd0, flags_lo}, {60'd0, m_lo});
    chk(req, "flags_hi", {60'd0, flags_hi}, {60'd0, m_hi});
    chk(trap ? "R9" : req, "tag_trap", {63'd0, tag_trap}, {63'd0, trap});
  endtask

  initial begin
    op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0; div_ovf = 1'b0;
    m_res = '0; m_lo = '0; m_hi = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while asserted
    chk("R1", "result in reset", result, 64'd0);
    chk("R1", "flags in reset", {56'd0, flags_hi, flags_lo}, 64'd0);
    chk("R1", "trap in reset", {63'd0, tag_trap}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after release", {56'd0, flags_hi, flags_lo}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].dov, req_name(VECS[i].req));
    end

    // R9: after a trap, the pulse has ended and nothing was written
    run_op(4'd3, 64'h2, 64'h8, 1'b0, "R9");
    @(negedge clk);
    chk("R9", "trap pulse ended", {63'd0, tag_trap}, 64'd0);
    chk("R9", "result kept", result, m_res);

    // R12: no change before the capturing edge
    @(negedge clk);
    op_valid = 1'b1; op_sel = 4'd0; opnd_a = 64'h1234; opnd_b = 64'h1;
    #2;
    chk("R12", "result before edge", result, m_res);
    @(negedge clk);
    op_valid = 1'b0;
    m_res = 64'h1235; m_lo = 4'b0000; m_hi = 4'b0000;
    chk("R12", "result after edge", result, 64'h1235);
    chk("R12", "flags after edge", {56'd0, flags_hi, flags_lo}, 64'd0);

    // R2: op_valid low ignores a loaded operation
    @(negedge clk);
    op_sel = 4'd4; opnd_a = 64'h0; opnd_b = 64'h5;
    repeat (2) @(negedge clk);
    chk("R2", "idle result", result, m_res);
    chk("R2", "idle flags", {56'd0, flags_hi, flags_lo}, {56'd0, m_hi, m_lo});

    // R2: codes 10 to 15 write nothing
    for (int c = 10; c < 16; c++) begin
      run_op(4'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 1'b1, "R2");
    end

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "re-reset", {55'd0, tag_trap, flags_hi, flags_lo} | result, 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule